// File: doc/BRIEF.md
# Snooped Sound Capture and I2S Stereo Emitter

This block sits beside a host machine's sound path. It watches the host's sound DMA acknowledge strobe and takes one 8-bit sample from the sound data bus on each rising edge of that strobe. It does not use the analogue output. The samples go into a capture FIFO. An external microcontroller drains that FIFO over a half-duplex 16-bit parallel bus, converts the sample rate and filters the audio, then writes 16-bit stereo frames back over the same bus into a playback FIFO.

A serial emitter takes one stereo frame from the playback FIFO at each frame boundary. It shifts the frame out in I2S form toward a video transmitter that carries the audio. The bit clock comes from a phase accumulator running on the system clock, so frame timing stays locked to the same clock that drives the video pipeline.

The host sends four interleaved 8-bit channels. In pairing mode, the block joins these into 16-bit words: positions 0 and 1 form one left sample, and positions 2 and 3 form one right sample. Capture uses a four-state channel-position machine: POS_CH0, POS_CH1, POS_CH2 and POS_CH3. It advances one state per strobe edge and wraps from POS_CH3 to POS_CH0. The emitter uses three states:
- TX_IDLE runs from reset until the first frame boundary, then moves to TX_LEFT.
- TX_LEFT moves to TX_RIGHT at the end of slot 15.
- TX_RIGHT moves back to TX_LEFT at the end of slot 31.

Top module: `snd_bridge`

## Requirements
- R1: A sample is taken only on a rising edge of `snd_ack`. A strobe held high for several cycles yields exactly one sample. A stored word makes `cap_empty` low in the cycle after the strobe's first high cycle.
- R2: With `pair_mode` low, each strobe stores the word {8'h00, byte}, so the upper byte is zero. Words leave the FIFO in arrival order.
- R3: The channel position starts at 0 after reset. It advances by one on every strobe edge in both modes and wraps from 3 to 0. Changing `pair_mode` does not reset it.
- R4: With `pair_mode` high, a strobe at an odd position stores {byte, low}. Here low is the byte taken at the most recent even position, in either mode. Position 1 therefore completes a left word and position 3 completes a right word. Strobes at even positions store nothing.
- R5: When the capture FIFO is full, a new word is dropped and `cap_ovf` pulses for one cycle. The words already stored are unchanged.
- R6: A read is `mcu_cs` high with `mcu_we` low. It pops the head word, and that word appears on `mcu_rdata` in the next cycle. A read of an empty FIFO returns 16'h0000 and pops nothing. `mcu_rdata` holds its value between reads.
- R7: A write with `mcu_sel`=0 loads the left holding register. A write with `mcu_sel`=1 supplies the right word and commits the frame {left, right}, with left in the upper half, to the playback FIFO. A commit while `play_full` is high is dropped.
- R8: Each frame is 32 bit clocks. `i2s_ws` is low for the 16 left slots and high for the 16 right slots. Data and word select change only on falling `i2s_bclk` and are sampled on the rising edge. Words go MSB first, with the MSB in the slot after the word-select edge.
- R9: Bit-clock half periods come from the carry of an accumulator of `ACC_W` bits. The accumulator adds 64·SAMPLE_HZ·2^ACC_W / CLK_HZ each cycle. With SAMPLE_HZ = CLK_HZ/256, a frame lasts exactly 256 cycles.
- R10: If the playback FIFO is empty at a frame boundary, the emitter sends the previous frame again. That frame is all zero after reset. `play_unf` pulses for one cycle at the start of that frame's slot 0.
- R11: Reset state: `i2s_bclk` 0, `i2s_ws` 1, `i2s_sdata` 0, `cap_empty` 1, `cap_ovf`, `play_unf`, `play_full` 0, `mcu_rdata` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_ack | input | 1 | Snooped sound DMA acknowledge strobe |
| snd_data | input | 8 | Snooped sound data byte |
| pair_mode | input | 1 | 1 = join channel bytes into 16-bit words |
| mcu_cs | input | 1 | Bus transfer this cycle |
| mcu_we | input | 1 | 1 = write, 0 = read |
| mcu_sel | input | 1 | Write target: 0 left holding, 1 right and commit |
| mcu_wdata | input | 16 | Write data |
| mcu_rdata | output | 16 | Registered read data |
| cap_empty | output | 1 | Capture FIFO empty |
| cap_ovf | output | 1 | One-cycle pulse on a dropped capture word |
| play_full | output | 1 | Playback FIFO full |
| play_unf | output | 1 | One-cycle pulse on a repeated frame |
| i2s_bclk | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word select, 0 = left |
| i2s_sdata | output | 1 | Serial data |

## Verification
On the capture side, a stored word shows on `cap_empty` and a drop shows on `cap_ovf` in the cycle after the strobe's first high cycle. Read data is due in the cycle after the read. A queue model of the FIFO, updated at every rising edge, is compared with these outputs at every falling edge, so each is checked in exactly the cycle it becomes due.

On the playback side, a frame appears on the lines only after the next frame boundary, which lies up to 256 cycles ahead. The bench therefore decodes the serial lines as a receiver would: it samples on rising `i2s_bclk` and checks that each word has 16 bits. It then compares the decoded frame sequence and the 256-cycle spacing of `play_unf` pulses. Writes are placed just after a boundary, so the whole batch lands before the next pop.

// File: rtl/snd_pkg.sv
`timescale 1ns/1ps
package snd_pkg;

    localparam int SAMPLE_W = 16;
    localparam int BYTE_W   = 8;

    // Position of the next snooped byte within the four-channel rotation
    typedef enum logic [1:0] {
        POS_CH0 = 2'd0,
        POS_CH1 = 2'd1,
        POS_CH2 = 2'd2,
        POS_CH3 = 2'd3
    } chan_pos_e;

    // Serial emitter phase
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_LEFT  = 2'd1,
        TX_RIGHT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_t;

endpackage

// File: rtl/snd_fifo.sv
`timescale 1ns/1ps
module snd_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp_q, rp_q;
    logic         do_push, do_pop;

    assign empty   = (wp_q == rp_q);
    assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q[AW-1:0]] <= wdata;
    end

endmodule

// File: rtl/snd_cap_asm.sv
`timescale 1ns/1ps
module snd_cap_asm
    import snd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                edge_seen,
    input  logic [BYTE_W-1:0]   byte_in,
    input  logic                pair_mode,
    output logic                word_push,
    output logic [SAMPLE_W-1:0] word_out
);
    chan_pos_e           pos_q, pos_d;
    logic [BYTE_W-1:0]   low_q;
    logic                odd_pos;

    assign odd_pos = (pos_q == POS_CH1) || (pos_q == POS_CH3);

    // Next position: one step per strobe edge, wrapping
    always_comb begin
        pos_d = pos_q;
        if (edge_seen) begin
            unique case (pos_q)
                POS_CH0: pos_d = POS_CH1;
                POS_CH1: pos_d = POS_CH2;
                POS_CH2: pos_d = POS_CH3;
                POS_CH3: pos_d = POS_CH0;
                default: pos_d = POS_CH0;
            endcase
        end
    end

    // Position register
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= POS_CH0;
        else        pos_q <= pos_d;
    end

    // Low byte remembered at even positions in either mode
    always_ff @(posedge clk) begin
        if (!rst_n)                   low_q <= '0;
        else if (edge_seen && !odd_pos) low_q <= byte_in;
    end

    // Outputs toward the capture FIFO
    always_comb begin
        if (pair_mode) begin
            word_push = edge_seen && odd_pos;
            word_out  = {byte_in, low_q};
        end else begin
            word_push = edge_seen;
            word_out  = {{(SAMPLE_W-BYTE_W){1'b0}}, byte_in};
        end
    end

endmodule

// File: rtl/snd_i2s_tx.sv
`timescale 1ns/1ps
module snd_i2s_tx
    import snd_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int SAMPLE_HZ = 44_100,
    parameter int ACC_W     = 24
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    frame_avail,
    input  stereo_t frame_in,
    output logic    frame_take,
    output logic    bclk,
    output logic    ws,
    output logic    sdata,
    output logic    underrun
);
    localparam int FRAME_BITS = 2 * SAMPLE_W;
    localparam int SLOT_W     = $clog2(FRAME_BITS);
    localparam logic [SLOT_W-1:0] SLOT_LAST   = SLOT_W'(FRAME_BITS - 1);
    localparam logic [SLOT_W-1:0] SLOT_L_LAST = SLOT_W'(SAMPLE_W - 1);
    // two half periods per slot
    localparam logic [63:0] STEP_WIDE =
        ((64'(SAMPLE_HZ) * 64'(2 * FRAME_BITS)) << ACC_W) / 64'(CLK_HZ);
    localparam logic [ACC_W-1:0] STEP = STEP_WIDE[ACC_W-1:0];

    tx_state_e             state_q, state_d;
    logic [ACC_W-1:0]      acc_q;
    logic [ACC_W:0]        acc_sum;
    logic                  tick, fall_evt, frame_start;
    logic [SLOT_W-1:0]     slot_q;
    logic [FRAME_BITS-1:0] shreg_q, last_q;

    assign acc_sum     = {1'b0, acc_q} + {1'b0, STEP};
    assign tick        = acc_sum[ACC_W];
    assign fall_evt    = tick && bclk;
    assign frame_start = fall_evt && (slot_q == SLOT_LAST);
    assign frame_take  = frame_start && frame_avail;

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_sum[ACC_W-1:0];
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (frame_start) state_d = TX_LEFT;
            TX_LEFT:  if (fall_evt && slot_q == SLOT_L_LAST) state_d = TX_RIGHT;
            TX_RIGHT: if (frame_start) state_d = TX_LEFT;
            default:  state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Line outputs and shifter, all moving on the falling half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk     <= 1'b0;
            ws       <= 1'b1;
            sdata    <= 1'b0;
            slot_q   <= SLOT_LAST;
            shreg_q  <= '0;
            last_q   <= '0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (tick) bclk <= !bclk;
            if (fall_evt) begin
                slot_q <= slot_q + 1'b1;
                ws     <= (state_d != TX_LEFT);
                sdata  <= shreg_q[FRAME_BITS-1];
                if (frame_start) begin
                    if (frame_avail) begin
                        shreg_q <= frame_in;
                        last_q  <= frame_in;
                    end else begin
                        shreg_q  <= last_q;
                        underrun <= 1'b1;
                    end
                end else begin
                    shreg_q <= shreg_q << 1;
                end
            end
        end
    end

endmodule

// File: rtl/snd_bridge.sv
`timescale 1ns/1ps
module snd_bridge
    import snd_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int SAMPLE_HZ  = 44_100,
    parameter int ACC_W      = 24,
    parameter int CAP_DEPTH  = 16,
    parameter int PLAY_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        snd_ack,
    input  logic [7:0]  snd_data,
    input  logic        pair_mode,
    input  logic        mcu_cs,
    input  logic        mcu_we,
    input  logic        mcu_sel,
    input  logic [15:0] mcu_wdata,
    output logic [15:0] mcu_rdata,
    output logic        cap_empty,
    output logic        cap_ovf,
    output logic        play_full,
    output logic        play_unf,
    output logic        i2s_bclk,
    output logic        i2s_ws,
    output logic        i2s_sdata
);
    localparam int FRAME_W = $bits(stereo_t);

    logic                ack_q, ack_rise;
    logic                cap_push, cap_full, rd_req;
    logic [SAMPLE_W-1:0] cap_word, cap_head;
    logic [SAMPLE_W-1:0] left_hold_q;
    logic                commit;
    stereo_t             play_in, play_head;
    logic                play_empty, play_take;

    // Strobe edge detect; follows the line through reset
    always_ff @(posedge clk) ack_q <= snd_ack;
    assign ack_rise = snd_ack && !ack_q;

    snd_cap_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_seen (ack_rise),
        .byte_in   (snd_data),
        .pair_mode (pair_mode),
        .word_push (cap_push),
        .word_out  (cap_word)
    );

    assign rd_req = mcu_cs && !mcu_we;

    snd_fifo #(.W(SAMPLE_W), .DEPTH(CAP_DEPTH)) u_cap_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cap_push),
        .wdata (cap_word),
        .pop   (rd_req),
        .rdata (cap_head),
        .empty (cap_empty),
        .full  (cap_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcu_rdata <= '0;
            cap_ovf   <= 1'b0;
        end else begin
            cap_ovf <= cap_push && cap_full;
            if (rd_req) mcu_rdata <= cap_empty ? '0 : cap_head;
        end
    end

    // Write side: left held until the right word commits the frame
    assign commit = mcu_cs && mcu_we && mcu_sel;

    always_ff @(posedge clk) begin
        if (!rst_n)                            left_hold_q <= '0;
        else if (mcu_cs && mcu_we && !mcu_sel) left_hold_q <= mcu_wdata;
    end

    assign play_in.left  = left_hold_q;
    assign play_in.right = mcu_wdata;

    snd_fifo #(.W(FRAME_W), .DEPTH(PLAY_DEPTH)) u_play_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (commit),
        .wdata (play_in),
        .pop   (play_take),
        .rdata (play_head),
        .empty (play_empty),
        .full  (play_full)
    );

    snd_i2s_tx #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .ACC_W(ACC_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_avail (!play_empty),
        .frame_in    (play_head),
        .frame_take  (play_take),
        .bclk        (i2s_bclk),
        .ws          (i2s_ws),
        .sdata       (i2s_sdata),
        .underrun    (play_unf)
    );

endmodule

// File: rtl/snd_bridge_chk.sv
`timescale 1ns/1ps
module snd_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        snd_ack,
    input logic        mcu_cs,
    input logic        mcu_we,
    input logic [15:0] mcu_rdata,
    input logic        cap_empty,
    input logic        cap_full,
    input logic        cap_push,
    input logic        cap_ovf,
    input logic        play_unf,
    input logic        i2s_bclk,
    input logic        i2s_ws,
    input logic        i2s_sdata
);
    // R1: the assembler only offers words on a strobe edge
    a_r1_push_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |-> $rose(snd_ack));

    // R5: dropping keeps the FIFO full when nothing is read
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_full && !(mcu_cs && !mcu_we)) |=> cap_full);

    // R5: an overflow pulse never coincides with an empty FIFO
    a_r5_ovf_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ovf |-> !cap_empty);

    // R6: empty read returns zero
    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_cs && !mcu_we && cap_empty) |=> (mcu_rdata == 16'h0000));

    // R6: the FIFO only drains through reads
    a_r6_empty_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_empty) |-> $past(mcu_cs && !mcu_we));

    // R8: word select moves only with a falling bit clock
    a_r8_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(i2s_ws) |-> $fell(i2s_bclk));

    // R8: data moves only with a falling bit clock
    a_r8_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(i2s_sdata) |-> $fell(i2s_bclk));

    // R10: underrun marks the start of a left slot 0
    a_r10_unf_at_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        play_unf |-> ($fell(i2s_bclk) && !i2s_ws));

endmodule

bind snd_bridge snd_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .snd_ack   (snd_ack),
    .mcu_cs    (mcu_cs),
    .mcu_we    (mcu_we),
    .mcu_rdata (mcu_rdata),
    .cap_empty (cap_empty),
    .cap_full  (cap_full),
    .cap_push  (cap_push),
    .cap_ovf   (cap_ovf),
    .play_unf  (play_unf),
    .i2s_bclk  (i2s_bclk),
    .i2s_ws    (i2s_ws),
    .i2s_sdata (i2s_sdata)
);

// File: tb/snd_bridge_tb.sv
`timescale 1ns/1ps
module snd_bridge_tb;
    localparam int CLK_HZ     = 100_000_000;
    localparam int SAMPLE_HZ  = 390_625;   // CLK_HZ/256: 256-cycle frame
    localparam int CAP_DEPTH  = 16;
    localparam int PLAY_DEPTH = 4;
    localparam int FRAME_CYC  = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snd_ack = 1'b0;
    logic [7:0]  snd_data = '0;
    logic        pair_mode = 1'b0;
    logic        mcu_cs = 1'b0, mcu_we = 1'b0, mcu_sel = 1'b0;
    logic [15:0] mcu_wdata = '0;
    logic [15:0] mcu_rdata;
    logic        cap_empty, cap_ovf, play_full, play_unf;
    logic        i2s_bclk, i2s_ws, i2s_sdata;

    snd_bridge #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .ACC_W(24),
                 .CAP_DEPTH(CAP_DEPTH), .PLAY_DEPTH(PLAY_DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .snd_ack(snd_ack), .snd_data(snd_data),
        .pair_mode(pair_mode), .mcu_cs(mcu_cs), .mcu_we(mcu_we),
        .mcu_sel(mcu_sel), .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata),
        .cap_empty(cap_empty), .cap_ovf(cap_ovf), .play_full(play_full),
        .play_unf(play_unf), .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws),
        .i2s_sdata(i2s_sdata)
    );

    always #5 clk = ~clk;

    int     checks = 0, errors = 0;
    longint cyc = 0;
    bit     finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- capture reference model ----------------
    logic [15:0] mq[$];
    bit          ack_prev_m = 0;
    int          pos_m = 0;
    logic [7:0]  lo_m = '0;
    logic [15:0] exp_rdata = '0;
    bit          exp_ovf = 0;
    bit          m_rise, m_push;
    int          m_pre;
    logic [15:0] m_word;
    int          ovf_cnt = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mq.delete(); pos_m = 0; lo_m = '0; exp_rdata = '0; exp_ovf = 0;
        end else begin
            m_rise = snd_ack && !ack_prev_m;
            m_pre  = mq.size();
            m_push = 0;
            exp_ovf = 0;
            m_word = '0;
            if (m_rise) begin
                if (!pair_mode) begin m_push = 1; m_word = {8'h00, snd_data}; end
                else if (pos_m % 2 == 1) begin m_push = 1; m_word = {snd_data, lo_m}; end
                if (pos_m % 2 == 0) lo_m = snd_data;
                pos_m = (pos_m + 1) % 4;
            end
            if (mcu_cs && !mcu_we) begin
                if (m_pre > 0) exp_rdata = mq.pop_front();
                else           exp_rdata = '0;
            end
            if (m_push) begin
                if (m_pre >= CAP_DEPTH) exp_ovf = 1;
                else                    mq.push_back(m_word);
            end
        end
        ack_prev_m = snd_ack;
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 cap_empty", cap_empty, (mq.size() == 0));
            chk("R5 cap_ovf", cap_ovf, exp_ovf);
            chk("R6 mcu_rdata", mcu_rdata, exp_rdata);
            if (cap_ovf) ovf_cnt++;
        end
    end

    // ---------------- I2S receiver model ----------------
    logic [31:0] rx_q[$];
    longint      unf_t[$];
    bit          bclk_prev = 0, ws_prev = 1, synced = 0;
    int          nbits = 0;
    logic [15:0] acc16 = '0, left_w = '0, word_w;

    always @(negedge clk) begin
        if (!rst_n) begin
            bclk_prev = 0; ws_prev = 1; synced = 0; nbits = 0; acc16 = '0;
        end else begin
            if (play_unf) unf_t.push_back(cyc);
            if (i2s_bclk && !bclk_prev) begin
                if (i2s_ws != ws_prev) begin
                    word_w = {acc16[14:0], i2s_sdata};
                    if (synced) begin
                        chk("R8 bits per word", nbits + 1, 16);
                        if (!ws_prev) left_w = word_w;
                        else          rx_q.push_back({left_w, word_w});
                    end
                    if (!i2s_ws) synced = 1;
                    nbits = 0; acc16 = '0;
                end else begin
                    acc16 = {acc16[14:0], i2s_sdata};
                    nbits++;
                end
                ws_prev = i2s_ws;
            end
            bclk_prev = i2s_bclk;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic strobe(input logic [7:0] b, input int len);
        @(negedge clk); snd_data = b; snd_ack = 1'b1;
        repeat (len) @(negedge clk);
        snd_ack = 1'b0;
    endtask

    task automatic mcu_read(output logic [15:0] v);
        @(negedge clk); mcu_cs = 1'b1; mcu_we = 1'b0;
        @(negedge clk); mcu_cs = 1'b0;
        v = mcu_rdata;
    endtask

    task automatic mcu_write(input logic sel, input logic [15:0] d);
        @(negedge clk); mcu_cs = 1'b1; mcu_we = 1'b1; mcu_sel = sel; mcu_wdata = d;
        @(negedge clk); mcu_cs = 1'b0; mcu_we = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        int t = 0;
        while (rx_q.size() < n && t < 20000) begin @(negedge clk); t++; end
        chk("R8 frames decoded in time", (rx_q.size() >= n), 1);
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    logic [15:0] v;
    logic [31:0] frames [5];

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 bclk", i2s_bclk, 0);
        chk("R11 ws", i2s_ws, 1);
        chk("R11 sdata", i2s_sdata, 0);
        chk("R11 cap_empty", cap_empty, 1);
        chk("R11 cap_ovf", cap_ovf, 0);
        chk("R11 play_full", play_full, 0);
        chk("R11 play_unf", play_unf, 0);
        chk("R11 rdata", mcu_rdata, 0);
        rst_n = 1'b1;

        // R1/R2: normal mode, one long strobe counted once
        strobe(8'hA1, 3);
        chk("R1 empty low after strobe", cap_empty, 0);
        strobe(8'h5C, 1);
        strobe(8'hF0, 2);
        mcu_read(v); chk("R2 first word", v, 16'h00A1);
        mcu_read(v); chk("R2 second word", v, 16'h005C);
        mcu_read(v); chk("R2 third word", v, 16'h00F0);
        mcu_read(v); chk("R1 long strobe once / R6 empty read", v, 16'h0000);
        chk("R6 empty after drain", cap_empty, 1);

        // R3: position carries into pairing mode (now at position 3)
        pair_mode = 1'b1;
        strobe(8'h3D, 1);
        mcu_read(v); chk("R3 position carried across mode", v, 16'h3DF0);
        // R4: even position stores nothing
        strobe(8'h11, 1);
        @(negedge clk);
        chk("R4 even position stores nothing", cap_empty, 1);
        strobe(8'h22, 1);
        strobe(8'h33, 1);
        strobe(8'h44, 1);
        mcu_read(v); chk("R4 left word", v, 16'h2211);
        mcu_read(v); chk("R4 right word", v, 16'h4433);

        // R5: overflow drops the seventeenth word
        pair_mode = 1'b0;
        ovf_cnt = 0;
        for (int i = 0; i < CAP_DEPTH + 1; i++) strobe(8'h80 + 8'(i), 1);
        @(negedge clk);
        chk("R5 overflow pulse count", ovf_cnt, 1);
        for (int i = 0; i < CAP_DEPTH; i++) begin
            mcu_read(v); chk("R5 stored word intact", v, {8'h00, 8'h80 + 8'(i)});
        end
        chk("R5 dropped word absent", cap_empty, 1);

        // R10/R9: idle playback repeats zero frames every 256 cycles
        wait_rx(3);
        for (int i = 0; i < 3; i++) chk("R10 zero frame on underflow", rx_q[i], 32'h0);
        chk("R10 underflow pulses seen", (unf_t.size() >= 2), 1);
        if (unf_t.size() >= 2)
            chk("R9 frame period", 32'(unf_t[unf_t.size()-1] - unf_t[unf_t.size()-2]), FRAME_CYC);

        // R7: write five frames just after a boundary; fifth is dropped
        begin
            int n0 = unf_t.size();
            int t = 0;
            while (unf_t.size() == n0 && t < 2000) begin @(negedge clk); t++; end
        end
        repeat (10) @(negedge clk);
        rx_q.delete();
        for (int k = 0; k < 5; k++) begin
            frames[k] = {16'hC3A0 + 16'(k), 16'h5A10 + 16'(k)};
            mcu_write(1'b0, frames[k][31:16]);
            mcu_write(1'b1, frames[k][15:0]);
            if (k == 2) chk("R7 not full after three", play_full, 0);
            if (k == 3) chk("R7 full after four", play_full, 1);
        end
        wait_rx(6);
        chk("R10 frame in flight", rx_q[0], 32'h0);
        for (int k = 0; k < 4; k++) chk("R8 R7 decoded frame", rx_q[k+1], frames[k]);
        chk("R7 commit while full dropped, R10 repeat", rx_q[5], frames[3]);
        chk("R7 full cleared after drain", play_full, 0);

        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

endmodule